// File: doc/BRIEF.md
# Routing-Tag Push Match-Action Stage

This block is one stage of a packet-processing pipeline. It takes a parsed header vector made of an Ethernet destination address, a VLAN header and a routing-tag header slot. It looks up the pair (destination MAC, VLAN ID) in a small associative table with exact matching. When an entry hits and the VLAN header is present, the stage inserts a four-hop routing tag behind the VLAN header. The VLAN's previous ethertype moves into the new tag. The VLAN ethertype becomes the tag marker 0xAAAA. The tag's hop bytes and an output-port metadata field are taken from the matching entry.

Table entries are loaded through an index/data write port. Each entry holds a valid bit, the two key fields, four hop bytes and an output port. Header vectors enter and leave with valid/ready handshakes. The result of a lookup appears one cycle after the vector is accepted.

Top module: `rtag_push_stage`

## Requirements
- R1: An entry hits only when its valid bit is set and both the 48-bit destination MAC and the 12-bit VLAN ID equal the stored key exactly.
- R2: On a hit with the VLAN header valid, the output tag is marked valid, its ethertype equals the input VLAN ethertype before the rewrite, and the output VLAN ethertype is 0xAAAA.
- R3: On such a hit, the output tag hop bytes are loaded from the entry, with up1 in bits [31:24], up2 in [23:16], down1 in [15:8] and down2 in [7:0]. The output port is loaded from the entry and out_port_valid is 1.
- R4: On a miss, every output header field equals its input value, out_port_valid is 0 and out_port is 0.
- R5: When in_vlan_valid is 0, the header vector passes through unchanged and out_port_valid is 0, even if the key matches an entry.
- R6: When several entries match, the entry with the lowest index supplies the action.
- R7: A write with cfg_entry_valid set to 0 removes an entry. A lookup accepted in the cycle after a write sees the new contents.
- R8: A vector accepted on a clock edge (in_valid and in_ready both high) shows up on the outputs with out_valid high after that edge.
- R9: While out_valid is high and out_ready is low, in_ready is low and all outputs stay unchanged.
- R10: After reset, out_valid is 0, in_ready is 1 and every table entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_entry_valid | input | 1 | Valid bit written into the entry |
| cfg_dmac | input | 48 | Key: destination MAC |
| cfg_vid | input | 12 | Key: VLAN ID |
| cfg_hops | input | 32 | Hop bytes up1, up2, down1, down2 (from MSB to LSB) |
| cfg_port | input | 4 | Output port action parameter |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Stage can accept a vector |
| in_dmac | input | 48 | Destination MAC |
| in_vlan_valid | input | 1 | VLAN header present |
| in_vid | input | 12 | VLAN ID |
| in_vlan_etype | input | 16 | VLAN ethertype |
| in_tag_valid | input | 1 | Routing-tag header present |
| in_tag_hops | input | 32 | Routing-tag hop bytes |
| in_tag_etype | input | 16 | Routing-tag ethertype |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream accepts the output |
| out_dmac | output | 48 | Destination MAC |
| out_vlan_valid | output | 1 | VLAN header present |
| out_vid | output | 12 | VLAN ID |
| out_vlan_etype | output | 16 | VLAN ethertype after the action |
| out_tag_valid | output | 1 | Routing-tag header present |
| out_tag_hops | output | 32 | Routing-tag hop bytes |
| out_tag_etype | output | 16 | Routing-tag ethertype |
| out_port_valid | output | 1 | Output port was set by the action |
| out_port | output | 4 | Output port metadata |

## Verification
The bench loads two entries that share one key, so a selector that favours the highest index returns the wrong hops and port. It probes keys that differ from a stored key by a single MAC bit or by one VLAN ID. A design that compares only part of the key would hit on these. Each hit checks the tag ethertype against the original VLAN ethertype, which catches a design that copies the field after writing 0xAAAA into it. The bench also sends a matching key with the VLAN header absent, removes an entry and looks it up in the very next cycle, and stalls the output so that a design that drops or overwrites a held result is caught.

// File: rtl/rtag_pkg.sv
package rtag_pkg;
  localparam int MAC_W   = 48;
  localparam int VID_W   = 12;
  localparam int ETYPE_W = 16;
  localparam int HOP_W   = 8;
  localparam int NHOPS   = 4;
  localparam int HOPS_W  = HOP_W * NHOPS;
  localparam logic [ETYPE_W-1:0] TAG_MARK = 16'hAAAA;
endpackage

// File: rtl/rtag_prio.sv
module rtag_prio #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  // lowest set index wins: scan from top so lower indices overwrite
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtag_table.sv
module rtag_table
  import rtag_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [MAC_W-1:0]  wr_dmac,
  input  logic [VID_W-1:0]  wr_vid,
  input  logic [HOPS_W-1:0] wr_hops,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [MAC_W-1:0]  key_dmac,
  input  logic [VID_W-1:0]  key_vid,
  output logic              hit,
  output logic [HOPS_W-1:0] hit_hops,
  output logic [PORT_W-1:0] hit_port
);
  logic              ent_valid [DEPTH];
  logic [MAC_W-1:0]  ent_dmac  [DEPTH];
  logic [VID_W-1:0]  ent_vid   [DEPTH];
  logic [HOPS_W-1:0] ent_hops  [DEPTH];
  logic [PORT_W-1:0] ent_port  [DEPTH];
  logic [DEPTH-1:0]  ent_we;
  logic [DEPTH-1:0]  match;
  logic [IDX_W-1:0]  sel;

  // per-entry write decode and key compare
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign ent_we[i] = wr_en && (wr_idx == IDX_W'(i));
    assign match[i]  = ent_valid[i] && (ent_dmac[i] == key_dmac)
                                    && (ent_vid[i] == key_vid);
  end

  // valid bits: reset to empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ent_valid[i] <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (ent_we[i]) ent_valid[i] <= wr_valid;
    end
  end

  // payload storage: no reset, enable only
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_we[i]) begin
        ent_dmac[i] <= wr_dmac;
        ent_vid[i]  <= wr_vid;
        ent_hops[i] <= wr_hops;
        ent_port[i] <= wr_port;
      end
    end
  end

  rtag_prio #(.N(DEPTH), .IDX_W(IDX_W)) u_prio (
    .req (match),
    .idx (sel),
    .any (hit)
  );

  assign hit_hops = ent_hops[sel];
  assign hit_port = ent_port[sel];

  // R1
  hit_key_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ent_valid[sel] && ent_dmac[sel] == key_dmac && ent_vid[sel] == key_vid));

  // R6
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((match & ((DEPTH'(1) << sel) - DEPTH'(1))) == '0));
endmodule

// File: rtl/rtag_action.sv
module rtag_action
  import rtag_pkg::*;
#(
  parameter int PORT_W = 4
) (
  input  logic               hit,
  input  logic               vlan_valid,
  input  logic [ETYPE_W-1:0] vlan_etype,
  input  logic               tag_valid_i,
  input  logic [HOPS_W-1:0]  tag_hops_i,
  input  logic [ETYPE_W-1:0] tag_etype_i,
  input  logic [HOPS_W-1:0]  act_hops,
  input  logic [PORT_W-1:0]  act_port,
  output logic [ETYPE_W-1:0] vlan_etype_o,
  output logic               tag_valid_o,
  output logic [HOPS_W-1:0]  tag_hops_o,
  output logic [ETYPE_W-1:0] tag_etype_o,
  output logic               port_valid_o,
  output logic [PORT_W-1:0]  port_o
);
  logic apply;
  assign apply = hit && vlan_valid;

  // tag ethertype takes the pre-rewrite VLAN ethertype
  always_comb begin
    vlan_etype_o = vlan_etype;
    tag_valid_o  = tag_valid_i;
    tag_hops_o   = tag_hops_i;
    tag_etype_o  = tag_etype_i;
    port_valid_o = 1'b0;
    port_o       = '0;
    if (apply) begin
      tag_etype_o  = vlan_etype;
      vlan_etype_o = TAG_MARK;
      tag_valid_o  = 1'b1;
      tag_hops_o   = act_hops;
      port_valid_o = 1'b1;
      port_o       = act_port;
    end
  end
endmodule

// File: rtl/rtag_push_stage.sv
module rtag_push_stage
  import rtag_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int PORT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_entry_valid,
  input  logic [MAC_W-1:0]   cfg_dmac,
  input  logic [VID_W-1:0]   cfg_vid,
  input  logic [HOPS_W-1:0]  cfg_hops,
  input  logic [PORT_W-1:0]  cfg_port,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [MAC_W-1:0]   in_dmac,
  input  logic               in_vlan_valid,
  input  logic [VID_W-1:0]   in_vid,
  input  logic [ETYPE_W-1:0] in_vlan_etype,
  input  logic               in_tag_valid,
  input  logic [HOPS_W-1:0]  in_tag_hops,
  input  logic [ETYPE_W-1:0] in_tag_etype,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [MAC_W-1:0]   out_dmac,
  output logic               out_vlan_valid,
  output logic [VID_W-1:0]   out_vid,
  output logic [ETYPE_W-1:0] out_vlan_etype,
  output logic               out_tag_valid,
  output logic [HOPS_W-1:0]  out_tag_hops,
  output logic [ETYPE_W-1:0] out_tag_etype,
  output logic               out_port_valid,
  output logic [PORT_W-1:0]  out_port
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  logic              hit;
  logic [HOPS_W-1:0] hit_hops;
  logic [PORT_W-1:0] hit_port;

  rtag_table #(.DEPTH(DEPTH), .PORT_W(PORT_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_valid (cfg_entry_valid),
    .wr_dmac  (cfg_dmac),
    .wr_vid   (cfg_vid),
    .wr_hops  (cfg_hops),
    .wr_port  (cfg_port),
    .key_dmac (in_dmac),
    .key_vid  (in_vid),
    .hit      (hit),
    .hit_hops (hit_hops),
    .hit_port (hit_port)
  );

  logic [ETYPE_W-1:0] a_vlan_etype, a_tag_etype;
  logic               a_tag_valid, a_port_valid;
  logic [HOPS_W-1:0]  a_tag_hops;
  logic [PORT_W-1:0]  a_port;

  rtag_action #(.PORT_W(PORT_W)) u_act (
    .hit          (hit),
    .vlan_valid   (in_vlan_valid),
    .vlan_etype   (in_vlan_etype),
    .tag_valid_i  (in_tag_valid),
    .tag_hops_i   (in_tag_hops),
    .tag_etype_i  (in_tag_etype),
    .act_hops     (hit_hops),
    .act_port     (hit_port),
    .vlan_etype_o (a_vlan_etype),
    .tag_valid_o  (a_tag_valid),
    .tag_hops_o   (a_tag_hops),
    .tag_etype_o  (a_tag_etype),
    .port_valid_o (a_port_valid),
    .port_o       (a_port)
  );

  // handshake: next-state
  logic accept, valid_en, valid_n;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign valid_en = in_ready;
  assign valid_n  = in_valid;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      out_valid <= 1'b0;
    else if (valid_en) out_valid <= valid_n;
  end

  // output data register: load enable only
  always_ff @(posedge clk) begin
    if (accept) begin
      out_dmac       <= in_dmac;
      out_vlan_valid <= in_vlan_valid;
      out_vid        <= in_vid;
      out_vlan_etype <= a_vlan_etype;
      out_tag_valid  <= a_tag_valid;
      out_tag_hops   <= a_tag_hops;
      out_tag_etype  <= a_tag_etype;
      out_port_valid <= a_port_valid;
      out_port       <= a_port;
    end
  end

  // R8
  accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_dmac) && $stable(out_vlan_etype)
      && $stable(out_tag_hops) && $stable(out_port_valid) && $stable(out_port)));

  // R2
  rewrite_link_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && hit && in_vlan_valid) |=> (out_tag_valid && out_vlan_etype == TAG_MARK
      && out_tag_etype == $past(in_vlan_etype)));

  // R5
  novlan_noact_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !in_vlan_valid) |=> (!out_port_valid && out_vlan_etype == $past(in_vlan_etype)));

  // R4
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (accept && !hit) |=> (!out_port_valid && out_tag_hops == $past(in_tag_hops)
      && out_tag_valid == $past(in_tag_valid)));
endmodule

// File: tb/sim_rtag_push_stage.sv
module sim_rtag_push_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_entry_valid;
  logic [3:0]  cfg_idx, cfg_port;
  logic [47:0] cfg_dmac;
  logic [11:0] cfg_vid;
  logic [31:0] cfg_hops;
  logic        in_valid, in_ready, in_vlan_valid, in_tag_valid;
  logic [47:0] in_dmac;
  logic [11:0] in_vid;
  logic [15:0] in_vlan_etype, in_tag_etype;
  logic [31:0] in_tag_hops;
  logic        out_valid, out_ready, out_vlan_valid, out_tag_valid, out_port_valid;
  logic [47:0] out_dmac;
  logic [11:0] out_vid;
  logic [15:0] out_vlan_etype, out_tag_etype;
  logic [31:0] out_tag_hops;
  logic [3:0]  out_port;

  always #5 clk = ~clk;

  rtag_push_stage u0 (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [47:0] MAC_A = 48'h0011_2233_4455;
  localparam logic [47:0] MAC_B = 48'h00AA_BBCC_DDEE;
  localparam logic [47:0] MAC_C = 48'hFFFF_FFFF_FFFE;
  localparam logic [31:0] PT_HOPS  = 32'h5A5A_0F0F;
  localparam logic [15:0] PT_ETYPE = 16'h1234;

  typedef struct packed {
    logic [47:0] dmac;
    logic [11:0] vid;
    logic        vv;
    logic [15:0] et;
    logic        hit;
    logic [31:0] hops;
    logic [3:0]  port;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{MAC_A, 12'd10,   1'b1, 16'h0800, 1'b1, 32'h1122_3344, 4'd3},  // R1 R6 dup key, idx 2 wins
    '{MAC_B, 12'd20,   1'b1, 16'h86DD, 1'b1, 32'h99AA_BBCC, 4'd1},  // R2 R3
    '{MAC_A, 12'd11,   1'b1, 16'h0800, 1'b0, 32'h0,         4'd0},  // R1 vid off by one
    '{MAC_A ^ 48'h1, 12'd10, 1'b1, 16'h0800, 1'b0, 32'h0,   4'd0},  // R1 one mac bit
    '{MAC_C, 12'hFFF,  1'b1, 16'h88CC, 1'b1, 32'h0102_0304, 4'd15}, // R3 last index
    '{MAC_B, 12'd20,   1'b0, 16'h86DD, 1'b0, 32'h0,         4'd0},  // R5 no vlan
    '{MAC_B, 12'd21,   1'b1, 16'h86DD, 1'b0, 32'h0,         4'd0},  // R4
    '{48'h0, 12'd0,    1'b1, 16'h0000, 1'b0, 32'h0,         4'd0}   // R10 empty entries
  };

  task automatic wr(input logic [3:0] idx, input logic v, input logic [47:0] m,
                    input logic [11:0] vid, input logic [31:0] h, input logic [3:0] p);
    cfg_we = 1; cfg_idx = idx; cfg_entry_valid = v;
    cfg_dmac = m; cfg_vid = vid; cfg_hops = h; cfg_port = p;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1; in_dmac = v.dmac; in_vid = v.vid; in_vlan_valid = v.vv;
    in_vlan_etype = v.et; in_tag_valid = 0; in_tag_hops = PT_HOPS; in_tag_etype = PT_ETYPE;
  endtask

  task automatic expect_out(string req, input vec_t v);
    check({req, " valid"}, 64'(out_valid), 64'(1));
    check({req, " dmac"}, 64'(out_dmac), 64'(v.dmac));
    check({req, " vid"}, 64'(out_vid), 64'(v.vid));
    if (v.hit) begin
      check({req, " tag_valid"}, 64'(out_tag_valid), 64'(1));
      check({req, " tag_etype"}, 64'(out_tag_etype), 64'(v.et));
      check({req, " vlan_etype"}, 64'(out_vlan_etype), 64'(16'hAAAA));
      check({req, " hops"}, 64'(out_tag_hops), 64'(v.hops));
      check({req, " port"}, 64'({out_port_valid, out_port}), 64'({1'b1, v.port}));
    end else begin
      check({req, " tag_valid"}, 64'(out_tag_valid), 64'(0));
      check({req, " tag_etype"}, 64'(out_tag_etype), 64'(PT_ETYPE));
      check({req, " vlan_etype"}, 64'(out_vlan_etype), 64'(v.et));
      check({req, " hops"}, 64'(out_tag_hops), 64'(PT_HOPS));
      check({req, " port"}, 64'({out_port_valid, out_port}), 64'(0));
    end
  endtask

  task automatic send(string req, input vec_t v);
    drive(v);
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    expect_out(req, v);
  endtask

  initial begin
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_entry_valid = 0; cfg_dmac = 0;
    cfg_vid = 0; cfg_hops = 0; cfg_port = 0; in_valid = 0; in_dmac = 0;
    in_vlan_valid = 0; in_vid = 0; in_vlan_etype = 0; in_tag_valid = 0;
    in_tag_hops = 0; in_tag_etype = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 out_valid", 64'(out_valid), 64'(0));
    check("R10 in_ready", 64'(in_ready), 64'(1));

    wr(4'd2,  1, MAC_A, 12'd10,  32'h1122_3344, 4'd3);
    wr(4'd5,  1, MAC_A, 12'd10,  32'h5566_7788, 4'd7);
    wr(4'd7,  1, MAC_B, 12'd20,  32'h99AA_BBCC, 4'd1);
    wr(4'd15, 1, MAC_C, 12'hFFF, 32'h0102_0304, 4'd15);

    for (int i = 0; i < NV; i++) send($sformatf("vec%0d R1/R2/R3/R4/R5", i), VECS[i]);

    // R7 remove entry 2, look up next cycle: entry 5 now supplies the action
    wr(4'd2, 0, MAC_A, 12'd10, 32'h0, 4'd0);
    send("R7 after delete", '{MAC_A, 12'd10, 1'b1, 16'h0800, 1'b1, 32'h5566_7788, 4'd7});
    wr(4'd5, 0, MAC_A, 12'd10, 32'h0, 4'd0);
    send("R7 all deleted", '{MAC_A, 12'd10, 1'b1, 16'h0800, 1'b0, 32'h0, 4'd0});

    // R8 / R9 stall
    @(negedge clk);
    check("R8 idle", 64'(out_valid), 64'(0));
    out_ready = 0;
    drive(VECS[1]);
    @(posedge clk); @(negedge clk);
    check("R8 one-cycle", 64'(out_valid), 64'(1));
    check("R9 in_ready low", 64'(in_ready), 64'(0));
    drive(VECS[4]);
    @(posedge clk); @(negedge clk);
    expect_out("R9 held", VECS[1]);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    expect_out("R9 released", VECS[4]);
    @(posedge clk); @(negedge clk);
    check("R8 drain", 64'(out_valid), 64'(0));

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule